// File: doc/BRIEF.md
# Queued-Duty Pulse-Width Modulator

This block drives a single pulse-width modulated pin from a period counter. Software programs it over a small word-wide register port with four locations: control, status, duty sample and period. Duty values are not applied as soon as they are written. Each one goes into a four-entry queue, and the counter takes the next value from the head of that queue when a period starts. This lets software stream a series of duty settings that take effect cleanly, one per period, with no glitches in the middle of a period.

The counter steps on a tick. The tick comes from a selectable source (none, the core clock, or one of two external tick strobes) divided by a programmable prescaler. One period lasts the programmed period value plus two ticks. Writing the period register restarts the count at once and pulls a fresh duty value. A soft-reset control bit empties the queue, so a channel that is enabled again starts from a clean state. Three low-power request inputs (doze, wait, debug) freeze the counter and force the pin low, unless the matching allow bit in the control register is set.

Register map: address 0 is control, 1 is status, 2 is duty sample, 3 is period. Reads return data combinationally on `bus_rdata`.

Top module: `pwmq_top`

## Requirements
- R1: After reset, `pwm_out` is low and every readable register (control, status, active duty, period) reads as zero.
- R2: With period value P and active duty D, the counter runs from 0 to P+1, so one period is P+2 ticks. The pin is high while the count is below D, which makes D=0 constantly low and any D of P+2 or more constantly high.
- R3: Control bits 27:16 hold a prescale value N. The counter then advances once every N+1 ticks of the selected source.
- R4: A write to address 2 queues its low 16 bits in a 4-entry FIFO. Status bits 2:0 report how many entries are occupied.
- R5: A duty write while the FIFO already holds 4 entries is dropped. It sets status bit 7, which stays set until a soft reset.
- R6: The active duty changes only when a new period starts. Each start pops the head entry in write order. Setting the enable bit (control bit 0) while the block is stopped counts as a start.
- R7: If the FIFO is empty when a period starts, the previous active duty is kept.
- R8: A write to address 3 while running resets the count to zero, starts a new period with the new value, and pops the next queued duty.
- R9: Writing control with bit 8 set empties the FIFO, clears status bit 7 and sets the active duty to zero. Bit 8 reads back as zero.
- R10: Writing control with bit 0 clear drives `pwm_out` low and parks the count at zero. Enabling again starts a fresh period at count zero.
- R11: While `doze_req`, `wait_req` or `dbg_req` is high and the matching allow bit (control bits 1, 2, 3) is clear, `pwm_out` is low and the count holds; it resumes from the held value afterwards. With the allow bit set, the request has no effect.
- R12: Control bits 5:4 select the tick source: 0 none (count frozen), 1 every core clock, 2 `alt_tick_a`, 3 `alt_tick_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| alt_tick_a | input | 1 | External tick strobe, source 2 |
| alt_tick_b | input | 1 | External tick strobe, source 3 |
| doze_req | input | 1 | Doze low-power request |
| wait_req | input | 1 | Wait low-power request |
| dbg_req | input | 1 | Debug-halt request |
| pwm_out | output | 1 | Modulated output |

## Verification
The assertions assume that only one register write happens per cycle. They also assume the period register changes only through its own write, which also restarts the count. Under these assumptions, the count never passes the period's last value, and the active duty moves only on a start or a clear.

The stimulus keeps to these assumptions. It issues one write per cycle, aligned to the falling edge. It changes the low-power and tick inputs only on falling edges, well away from the register updates. Expected pin levels come from the count and prescale arithmetic across a sweep of small periods, duties and dividers.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;
  localparam logic [1:0] A_CTRL   = 2'd0;
  localparam logic [1:0] A_STAT   = 2'd1;
  localparam logic [1:0] A_SAMPLE = 2'd2;
  localparam logic [1:0] A_PERIOD = 2'd3;

  localparam int unsigned C_EN       = 0;
  localparam int unsigned C_DOZE_OK  = 1;
  localparam int unsigned C_WAIT_OK  = 2;
  localparam int unsigned C_DBG_OK   = 3;
  localparam int unsigned C_SRC_LO   = 4;
  localparam int unsigned C_SOFT_RST = 8;
  localparam int unsigned C_PRE_LO   = 16;
  localparam int unsigned ST_OVF     = 7;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_CORE  = 2'd1,
    SRC_ALT_A = 2'd2,
    SRC_ALT_B = 2'd3
  } src_sel_e;
endpackage

// File: rtl/pwmq_fifo.sv
module pwmq_fifo #(
  parameter int unsigned W      = 16,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [W-1:0]      push_data,
  input  logic              pop,
  input  logic              flush,
  output logic [W-1:0]      head,
  output logic [FILL_W-1:0] fill,
  output logic              full,
  output logic              empty
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]      mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_d;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic              push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (fill_q == FILL_W'(DEPTH));
  assign empty   = (fill_q == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign head    = mem_q[rd_ptr_q];
  assign fill    = fill_q;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    fill_d   = fill_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      fill_d   = '0;
    end else begin
      if (push_ok) wr_ptr_d = ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_d = ptr_inc(rd_ptr_q);
      fill_d = fill_q + FILL_W'(push_ok) - FILL_W'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      fill_q   <= fill_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic we;
    assign we = push_ok && (wr_ptr_q == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (we) mem_q[g] <= push_data;
    end
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FILL_W'(DEPTH)); // R4
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (fill_q == FILL_W'(DEPTH))); // R5
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fill_q == '0)); // R9
endmodule

// File: rtl/pwmq_prescale.sv
module pwmq_prescale #(
  parameter int unsigned PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q, pre_d;

  assign tick = step && (pre_q >= div);

  always_comb begin
    pre_d = pre_q;
    if (restart)   pre_d = '0;
    else if (tick) pre_d = '0;
    else if (step) pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pre_q == '0)); // R3
endmodule

// File: rtl/pwmq_core.sv
module pwmq_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             halt,
  input  logic             tick,
  input  logic             restart,
  input  logic             start,
  input  logic             clear,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] head,
  input  logic             head_valid,
  output logic             pop,
  output logic [CNT_W-1:0] duty_act,
  output logic             pwm_out
);
  localparam int unsigned CW = CNT_W + 1;

  logic [CW-1:0]    cnt_q, cnt_d;
  logic [CNT_W-1:0] duty_q, duty_d;
  logic             last, wrap, load, step;

  assign step = run && !halt && tick;
  assign last = (cnt_q == ({1'b0, period} + CW'(1)));
  assign wrap = step && last && !restart;
  assign load = start || wrap;
  assign pop  = load && head_valid && !clear;

  always_comb begin
    cnt_d = cnt_q;
    if (!run || restart) cnt_d = '0;
    else if (step)       cnt_d = last ? '0 : cnt_q + 1'b1;
  end

  always_comb begin
    duty_d = duty_q;
    if (clear)                   duty_d = '0;
    else if (load && head_valid) duty_d = head;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      duty_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      duty_q <= duty_d;
    end
  end

  assign duty_act = duty_q;
  assign pwm_out  = run && !halt && ({1'b0, duty_q} > cnt_q);

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ({1'b0, period} + CW'(1))); // R2
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && halt && !restart) |=> $stable(cnt_q)); // R11
  AST_DUTY_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !step && !clear) |=> $stable(duty_q)); // R6
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/pwmq_top.sv
module pwmq_top #(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned PRE_W      = 12,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              alt_tick_a,
  input  logic              alt_tick_b,
  input  logic              doze_req,
  input  logic              wait_req,
  input  logic              dbg_req,
  output logic              pwm_out
);
  import pwmq_pkg::*;

  localparam int unsigned FILL_W = $clog2(FIFO_DEPTH + 1);

  logic             en_q, en_d;
  logic             dz_ok_q, dz_ok_d;
  logic             wt_ok_q, wt_ok_d;
  logic             db_ok_q, db_ok_d;
  src_sel_e         src_q, src_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] period_q, period_d;
  logic             ovf_q, ovf_d;

  logic ctrl_wr, sample_wr, period_wr, soft_rst;
  logic en_rise, restart, start, halt, src_tick, tick;
  logic fifo_pop, fifo_full, fifo_empty;
  logic [CNT_W-1:0]  fifo_head, duty_act;
  logic [FILL_W-1:0] fifo_fill;

  assign ctrl_wr   = bus_wr && (bus_addr == A_CTRL);
  assign sample_wr = bus_wr && (bus_addr == A_SAMPLE);
  assign period_wr = bus_wr && (bus_addr == A_PERIOD);
  assign soft_rst  = ctrl_wr && bus_wdata[C_SOFT_RST];
  assign en_rise   = ctrl_wr && bus_wdata[C_EN] && !en_q;
  assign restart   = period_wr || en_rise;
  assign start     = en_rise || (period_wr && en_q);

  assign halt = (doze_req && !dz_ok_q) || (wait_req && !wt_ok_q) ||
                (dbg_req && !db_ok_q);

  always_comb begin
    case (src_q)
      SRC_CORE:  src_tick = 1'b1;
      SRC_ALT_A: src_tick = alt_tick_a;
      SRC_ALT_B: src_tick = alt_tick_b;
      default:   src_tick = 1'b0;
    endcase
  end

  always_comb begin
    en_d     = en_q;
    dz_ok_d  = dz_ok_q;
    wt_ok_d  = wt_ok_q;
    db_ok_d  = db_ok_q;
    src_d    = src_q;
    pre_d    = pre_q;
    period_d = period_q;
    ovf_d    = ovf_q;
    if (ctrl_wr) begin
      en_d    = bus_wdata[C_EN];
      dz_ok_d = bus_wdata[C_DOZE_OK];
      wt_ok_d = bus_wdata[C_WAIT_OK];
      db_ok_d = bus_wdata[C_DBG_OK];
      src_d   = src_sel_e'(bus_wdata[C_SRC_LO +: 2]);
      pre_d   = bus_wdata[C_PRE_LO +: PRE_W];
    end
    if (period_wr) period_d = bus_wdata[CNT_W-1:0];
    if (soft_rst)                    ovf_d = 1'b0;
    else if (sample_wr && fifo_full) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      dz_ok_q  <= 1'b0;
      wt_ok_q  <= 1'b0;
      db_ok_q  <= 1'b0;
      src_q    <= SRC_NONE;
      pre_q    <= '0;
      period_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      en_q     <= en_d;
      dz_ok_q  <= dz_ok_d;
      wt_ok_q  <= wt_ok_d;
      db_ok_q  <= db_ok_d;
      src_q    <= src_d;
      pre_q    <= pre_d;
      period_q <= period_d;
      ovf_q    <= ovf_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[C_EN]               = en_q;
        bus_rdata[C_DOZE_OK]          = dz_ok_q;
        bus_rdata[C_WAIT_OK]          = wt_ok_q;
        bus_rdata[C_DBG_OK]           = db_ok_q;
        bus_rdata[C_SRC_LO +: 2]      = src_q;
        bus_rdata[C_PRE_LO +: PRE_W]  = pre_q;
      end
      A_STAT: begin
        bus_rdata[FILL_W-1:0] = fifo_fill;
        bus_rdata[ST_OVF]     = ovf_q;
      end
      A_SAMPLE: bus_rdata[CNT_W-1:0] = duty_act;
      default:  bus_rdata[CNT_W-1:0] = period_q;
    endcase
  end

  pwmq_fifo #(.W(CNT_W), .DEPTH(FIFO_DEPTH), .FILL_W(FILL_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (sample_wr),
    .push_data (bus_wdata[CNT_W-1:0]),
    .pop       (fifo_pop),
    .flush     (soft_rst),
    .head      (fifo_head),
    .fill      (fifo_fill),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  pwmq_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .step    (en_q && !halt && src_tick),
    .div     (pre_q),
    .tick    (tick)
  );

  pwmq_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (en_q),
    .halt       (halt),
    .tick       (tick),
    .restart    (restart),
    .start      (start),
    .clear      (soft_rst),
    .period     (period_q),
    .head       (fifo_head),
    .head_valid (!fifo_empty),
    .pop        (fifo_pop),
    .duty_act   (duty_act),
    .pwm_out    (pwm_out)
  );

  AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !pwm_out); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !soft_rst) |=> ovf_q); // R5
endmodule

// File: tb/tb_pwmq_top.sv
module tb_pwmq_top;
  logic        clk, rst_n, bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        alt_tick_a, alt_tick_b, doze_req, wait_req, dbg_req, pwm_out;

  int n_chk = 0;
  int n_bad = 0;
  int seq [8];

  localparam logic [31:0] EN = 32'h1, OKS = 32'hE, SOFT = 32'h100;
  localparam logic [31:0] S_CORE = 32'h10, S_ALTA = 32'h20, S_ALTB = 32'h30;

  pwmq_top dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alt_tick_a(alt_tick_a),
    .alt_tick_b(alt_tick_b), .doze_req(doze_req), .wait_req(wait_req),
    .dbg_req(dbg_req), .pwm_out(pwm_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
    bus_addr = 2'd0;
  endtask

  task automatic set_seq(input int v);
    foreach (seq[i]) seq[i] = v;
  endtask

  task automatic run_seq(input int per, input int pdiv, input int k0, input int k1,
                         input string tag);
    for (int k = k0; k < k1; k++) begin
      int n, c, d;
      n = k / ((pdiv + 1) * (per + 2));
      c = (k / (pdiv + 1)) % (per + 2);
      d = seq[(n > 7) ? 7 : n];
      chk(tag, 32'(pwm_out), 32'(c < d));
      @(negedge clk);
    end
  endtask

  task automatic hold_level(input logic lvl, input int cyc, input string tag);
    for (int i = 0; i < cyc; i++) begin
      chk(tag, 32'(pwm_out), 32'(lvl));
      @(negedge clk);
    end
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    alt_tick_a = 1'b0; alt_tick_b = 1'b0;
    doze_req = 1'b0; wait_req = 1'b0; dbg_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 out", 32'(pwm_out), 0);
    rd(2'd0, v); chk("R1 ctrl", v, 0);
    rd(2'd1, v); chk("R1 status", v, 0);
    rd(2'd2, v); chk("R1 duty", v, 0);
    rd(2'd3, v); chk("R1 period", v, 0);
    @(negedge clk);

    // R2 R3 sweep of period, duty and prescale
    for (int p = 0; p < 6; p++)
      for (int d = 0; d < p + 4; d++)
        for (int q = 0; q < 3; q++) begin
          wr(2'd0, SOFT);
          wr(2'd3, 32'(p));
          wr(2'd2, 32'(d));
          wr(2'd0, EN | S_CORE | (32'(q) << 16));
          set_seq(d);
          run_seq(p, q, 0, 2 * (q + 1) * (p + 2), "R2_R3 sweep");
        end

    // R4 R5 R6 R7 queue order, overflow, reuse
    wr(2'd0, SOFT);
    wr(2'd3, 2);
    wr(2'd2, 1); wr(2'd2, 3); wr(2'd2, 0); wr(2'd2, 4);
    rd(2'd1, v); chk("R4 fill four", v, 32'h4);
    wr(2'd2, 1); wr(2'd2, 1);
    rd(2'd1, v); chk("R5 drop and flag", v, 32'h84);
    wr(2'd0, EN | S_CORE);
    rd(2'd1, v); chk("R6 enable pops one", v, 32'h83);
    seq = '{1, 3, 0, 4, 4, 4, 4, 4};
    run_seq(2, 0, 0, 32, "R6_R7 queued order");
    rd(2'd1, v); chk("R5 sticky after drain", v, 32'h80);

    // R6 write during a period waits for the boundary
    wr(2'd0, SOFT);
    wr(2'd3, 4);
    wr(2'd2, 2);
    wr(2'd0, EN | S_CORE);
    seq = '{2, 5, 5, 5, 5, 5, 5, 5};
    run_seq(4, 0, 0, 2, "R6 before write");
    wr(2'd2, 5);
    run_seq(4, 0, 3, 18, "R6 mid period write");

    // R8 period write restarts and pops
    wr(2'd0, SOFT);
    wr(2'd3, 7);
    wr(2'd2, 6);
    wr(2'd0, EN | S_CORE);
    set_seq(6);
    run_seq(7, 0, 0, 1, "R8 pre");
    wr(2'd2, 2);
    run_seq(7, 0, 2, 6, "R8 pre");
    wr(2'd3, 3);
    set_seq(2);
    rd(2'd1, v); chk("R8 popped", v, 0);
    run_seq(3, 0, 0, 10, "R8 restart");

    // R10 stop, then R7 reuse on re-enable
    wr(2'd0, S_CORE);
    hold_level(1'b0, 10, "R10 stopped");
    wr(2'd0, EN | S_CORE);
    run_seq(3, 0, 0, 10, "R10_R7 restart at zero");

    // R9 soft reset
    wr(2'd0, 0);
    for (int i = 0; i < 5; i++) wr(2'd2, 3);
    rd(2'd1, v); chk("R9 before flush", v, 32'h84);
    wr(2'd0, SOFT);
    rd(2'd1, v); chk("R9 status cleared", v, 0);
    rd(2'd2, v); chk("R9 duty cleared", v, 0);
    rd(2'd0, v); chk("R9 bit reads zero", v, 0);
    wr(2'd3, 2);
    wr(2'd0, EN | S_CORE);
    hold_level(1'b0, 8, "R9 no stale duty");

    // R11 low-power halt
    wr(2'd0, SOFT);
    wr(2'd3, 5);
    wr(2'd2, 3);
    wr(2'd0, EN | S_CORE);
    set_seq(3);
    run_seq(5, 0, 0, 2, "R11 pre");
    doze_req = 1'b1; #1;
    chk("R11 doze low", 32'(pwm_out), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R11 doze low", 32'(pwm_out), 0);
    end
    @(negedge clk); doze_req = 1'b0; #1;
    chk("R11 resume held count", 32'(pwm_out), 1);
    @(negedge clk); #1;
    chk("R11 count advanced", 32'(pwm_out), 0);
    repeat (4) @(negedge clk);
    #1; chk("R11 next period", 32'(pwm_out), 1);
    wait_req = 1'b1; #1; chk("R11 wait low", 32'(pwm_out), 0);
    wait_req = 1'b0; #1; chk("R11 wait off", 32'(pwm_out), 1);
    dbg_req = 1'b1; #1; chk("R11 debug low", 32'(pwm_out), 0);
    dbg_req = 1'b0;
    @(negedge clk);
    wr(2'd0, 0);
    doze_req = 1'b1; wait_req = 1'b1; dbg_req = 1'b1;
    wr(2'd0, EN | OKS | S_CORE);
    run_seq(5, 0, 0, 14, "R11 allowed modes");
    doze_req = 1'b0; wait_req = 1'b0; dbg_req = 1'b0;

    // R12 tick source select
    wr(2'd0, SOFT);
    wr(2'd3, 2);
    wr(2'd2, 2);
    wr(2'd0, EN);
    hold_level(1'b1, 8, "R12 no source frozen");
    wr(2'd0, 0);
    alt_tick_b = 1'b1;
    wr(2'd0, EN | S_ALTA);
    hold_level(1'b1, 6, "R12 alt a idle");
    alt_tick_a = 1'b1;
    set_seq(2);
    run_seq(2, 0, 0, 12, "R12 alt a ticking");
    wr(2'd0, 0);
    alt_tick_b = 1'b0;
    wr(2'd0, EN | S_ALTB);
    hold_level(1'b1, 6, "R12 alt b idle");
    alt_tick_b = 1'b1;
    run_seq(2, 0, 0, 8, "R12 alt b ticking");

    summary();
    $finish;
  end
endmodule